// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block is the logic-level model of one bidirectional pin cell of a programmable device. On the outgoing side it takes the core's data and drive-enable. It sends them to the pad either straight through or through storage elements clocked by a dedicated output clock. Either value may be inverted on the way out. On the incoming side it always returns the raw pad value to the core. It also returns a second, captured copy held in an element clocked by a separate input clock. That element can be set up as a rising-edge flip-flop or as a latch that is transparent while the input clock is high. An optional fixed delay sits in front of it, which trades a longer setup time for a zero hold requirement.

All storage sits on one fast sampling clock `clk`. The output and input clocks are level signals. Their rising edges and high phases are detected on `clk`. The input delay is a fixed number of `clk` cycles. A one-cycle global set/reset pulse, issued after configuration, loads every storage element with its configured start value. The pad is modelled as separate in, out and enable signals.

Top module: `pio_cell`

## Requirements
- R1: `cfg[7:0]` holds, from bit 7 down to bit 0: out_reg_en, oe_reg_en, oe_invert, out_invert, in_latch_mode, in_delay_en, out_init, in_init.
- R2: With out_reg_en=0, `pad_out` equals `core_out` XOR out_invert, with no clock delay.
- R3: With out_reg_en=1, the output register loads `core_out` on the first `clk` edge at which `out_clk` is sampled high after being sampled low. `pad_out` is that register XOR out_invert, and it holds at every other edge.
- R4: `pad_oe`=1 means the pad is driven. With oe_reg_en=0 it equals `core_oe` XOR oe_invert. With oe_reg_en=1 that value is registered on the same `out_clk` edge as the data.
- R5: `core_in_direct` always equals `pad_in`, whatever `pad_oe` is.
- R6: With in_latch_mode=0, `core_in_reg` changes only on a `clk` edge where `in_clk` rises (sampled high after low).
- R7: With in_latch_mode=1, `core_in_reg` follows the capture source at each `clk` edge while `in_clk` is high, and holds while it is low.
- R8: With in_delay_en=1, the capture source is `pad_in` as sampled DLY_CYCLES `clk` edges earlier (default 3). With in_delay_en=0 it is `pad_in` itself.
- R9: A `clk` edge with `gsr`=1 loads the output register with out_init and the input element with in_init, and clears the enable register (not driving). This overrides clock edges and latch transparency.
- R10: Asynchronous active-low `rst_n` clears all storage elements, the delay line and the clock-edge history to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast sampling clock for all storage |
| rst_n | input | 1 | asynchronous active-low reset |
| gsr | input | 1 | global set/reset pulse to configured start values |
| cfg | input | 8 | configuration word (see R1) |
| out_clk | input | 1 | output-side capture clock (level, edge-detected) |
| in_clk | input | 1 | input-side capture clock (level) |
| core_out | input | 1 | data from core to pad |
| core_oe | input | 1 | drive enable from core |
| pad_in | input | 1 | value seen on the pad |
| pad_out | output | 1 | data to the pad driver |
| pad_oe | output | 1 | pad driver enable, 1 = driving |
| core_in_direct | output | 1 | raw pad value to core |
| core_in_reg | output | 1 | captured pad value to core |

## Verification
The bench walks all sixteen output-side mode combinations. After a set/reset pulse, after an `out_clk` rise, and after a data change while `out_clk` stays high, it checks that registered paths hold and direct paths follow. A design that mixed up direct and registered paths, or applied inversion before the start value, would show the wrong pad level in one of those phases. The input element is driven with data changes during the high and low clock phases, and with clock rises. A latch that acted as a flip-flop, or the reverse, would miss or wrongly take those changes. The delay is tested by changing the pad in the same cycle as the capture clock rises: an absent or wrong-length delay captures the new value, or captures it too soon. Set/reset is raised together with a clock rise and with an open latch, to show that it wins.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef struct packed {
    logic out_reg_en;
    logic oe_reg_en;
    logic oe_invert;
    logic out_invert;
    logic in_latch_mode;
    logic in_delay_en;
    logic out_init;
    logic in_init;
  } pio_cfg_t;

  // Pick stored or raw value, then apply polarity.
  function automatic logic pio_drive(logic use_reg, logic q, logic d, logic inv);
    return (use_reg ? q : d) ^ inv;
  endfunction

  // Capture condition for the input element.
  function automatic logic pio_cap_en(logic latch_mode, logic level, logic rise);
    return latch_mode ? level : rise;
  endfunction
endpackage

// File: rtl/pio_edge.sv
module pio_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig;
  end
  assign rise = sig & ~prev;
endmodule

// File: rtl/pio_delay.sv
module pio_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = DEPTH - 1;
  logic [LAST:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= din;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= 1'b0;
        else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign dout = stage[LAST];
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path
  import pio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     gsr,
  input  logic     out_rise,
  input  pio_cfg_t cfg,
  input  logic     core_out,
  input  logic     core_oe,
  output logic     pad_out,
  output logic     pad_oe,
  output logic     oe_q
);
  logic out_q;
  logic oe_pol;

  assign oe_pol = core_oe ^ cfg.oe_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (gsr) begin
      out_q <= cfg.out_init;
      oe_q  <= 1'b0;
    end else if (out_rise) begin
      out_q <= core_out;
      oe_q  <= oe_pol;
    end
  end

  assign pad_out = pio_drive(cfg.out_reg_en, out_q, core_out, cfg.out_invert);
  assign pad_oe  = pio_drive(cfg.oe_reg_en, oe_q, oe_pol, 1'b0);
endmodule

// File: rtl/pio_in_path.sv
module pio_in_path
  import pio_pkg::*;
#(
  parameter int DLY_CYCLES = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     gsr,
  input  logic     in_rise,
  input  logic     in_level,
  input  pio_cfg_t cfg,
  input  logic     pad_in,
  output logic     core_in_reg
);
  logic delayed;
  logic cap_src;
  logic cap_en;

  pio_delay #(.DEPTH(DLY_CYCLES)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(delayed)
  );

  assign cap_src = cfg.in_delay_en ? delayed : pad_in;
  assign cap_en  = pio_cap_en(cfg.in_latch_mode, in_level, in_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      core_in_reg <= 1'b0;
    else if (gsr)    core_in_reg <= cfg.in_init;
    else if (cap_en) core_in_reg <= cap_src;
  end
endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
#(
  parameter int DLY_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gsr,
  input  logic [7:0] cfg,
  input  logic       out_clk,
  input  logic       in_clk,
  input  logic       core_out,
  input  logic       core_oe,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       core_in_direct,
  output logic       core_in_reg
);
  pio_cfg_t cfg_s;
  logic     out_rise;
  logic     in_rise;
  logic     oe_q;

  assign cfg_s = pio_cfg_t'(cfg);

  pio_edge u_out_edge (.clk(clk), .rst_n(rst_n), .sig(out_clk), .rise(out_rise));
  pio_edge u_in_edge  (.clk(clk), .rst_n(rst_n), .sig(in_clk),  .rise(in_rise));

  pio_out_path u_out (
    .clk(clk), .rst_n(rst_n), .gsr(gsr), .out_rise(out_rise), .cfg(cfg_s),
    .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .oe_q(oe_q)
  );

  pio_in_path #(.DLY_CYCLES(DLY_CYCLES)) u_in (
    .clk(clk), .rst_n(rst_n), .gsr(gsr), .in_rise(in_rise), .in_level(in_clk),
    .cfg(cfg_s), .pad_in(pad_in), .core_in_reg(core_in_reg)
  );

  assign core_in_direct = pad_in;
endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gsr,
  input logic [7:0] cfg,
  input logic       in_clk,
  input logic       pad_in,
  input logic       pad_out,
  input logic       core_in_direct,
  input logic       core_in_reg,
  input logic       out_rise,
  input logic       in_rise,
  input logic       oe_q
);
  always_comb begin
    if (rst_n) begin
      assert_direct_tap_R5: assert (core_in_direct == pad_in);
    end
  end

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[7] && !gsr && !out_rise) |=> ((cfg != $past(cfg)) || $stable(pad_out)));

  assert_ff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[3] && !gsr && !in_rise) |=> ((cfg != $past(cfg)) || $stable(core_in_reg)));

  assert_latch_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3] && !cfg[2] && in_clk && !gsr) |=> (core_in_reg == $past(pad_in)));

  assert_gsr_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |=> (core_in_reg == $past(cfg[0])));

  assert_gsr_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |=> !oe_q);
endmodule

bind pio_cell pio_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gsr(gsr), .cfg(cfg), .in_clk(in_clk),
  .pad_in(pad_in), .pad_out(pad_out), .core_in_direct(core_in_direct),
  .core_in_reg(core_in_reg), .out_rise(out_rise), .in_rise(in_rise), .oe_q(oe_q)
);

// File: tb/pio_cell_tb.sv
module pio_cell_tb;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gsr = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic out_clk = 1'b0, in_clk = 1'b0, core_out = 1'b0, core_oe = 1'b0, pad_in = 1'b0;
  logic pad_out, pad_oe, core_in_direct, core_in_reg;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pio_cell #(.DLY_CYCLES(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .gsr(gsr), .cfg(cfg), .out_clk(out_clk), .in_clk(in_clk),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .core_in_direct(core_in_direct), .core_in_reg(core_in_reg)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // cfg bits per R1: 7 out_reg_en,6 oe_reg_en,5 oe_inv,4 out_inv,3 latch,2 delay,1 out_init,0 in_init
  function automatic logic [7:0] mk(logic ore, logic oere, logic oei, logic oi,
                                    logic lat, logic dly, logic oin, logic iin);
    return {ore, oere, oei, oi, lat, dly, oin, iin};
  endfunction

  task automatic pulse_gsr();
    gsr = 1'b1; step(); gsr = 1'b0; #1;
  endtask

  task automatic t_reset();
    cfg = mk(1,1,0,0,0,0,1,1);
    #1;
    chk("R10 pad_out", pad_out, 1'b0);
    chk("R10 pad_oe", pad_oe, 1'b0);
    chk("R10 core_in_reg", core_in_reg, 1'b0);
  endtask

  task automatic t_out_modes();
    for (int m = 0; m < 16; m++) begin
      logic ore, oere, oei, oi, oin, d, e;
      ore = m[3]; oere = m[2]; oei = m[1]; oi = m[0];
      oin = m[0] ^ m[3];
      d = ~m[0]; e = m[3] ^ m[1];
      cfg = mk(ore, oere, oei, oi, 0, 0, oin, 0);
      out_clk = 1'b0; core_out = 1'b1; core_oe = 1'b1;
      pulse_gsr();
      chk("R9/R2/R3 out after gsr", pad_out, (ore ? oin : 1'b1) ^ oi);
      chk("R9/R4 oe after gsr", pad_oe, oere ? 1'b0 : ~oei);
      core_out = d; core_oe = e; out_clk = 1'b1;
      step(); #1;
      chk("R3 out on out_clk rise", pad_out, d ^ oi);
      chk("R4 oe on out_clk rise", pad_oe, e ^ oei);
      core_out = ~d; core_oe = ~e; #1;
      chk("R2/R3 out after data change", pad_out, (ore ? d : ~d) ^ oi);
      chk("R4 oe after enable change", pad_oe, (oere ? e : ~e) ^ oei);
      step(); #1;
      chk("R3 out held while out_clk high", pad_out, (ore ? d : ~d) ^ oi);
      chk("R4 oe held while out_clk high", pad_oe, (oere ? e : ~e) ^ oei);
      out_clk = 1'b0; step();
    end
  endtask

  task automatic t_ff();
    cfg = mk(0,0,0,0,0,0,0,1); in_clk = 1'b0; pad_in = 1'b1;
    core_out = 1'b0; core_oe = 1'b1;
    pulse_gsr();
    chk("R9 in_init loaded", core_in_reg, 1'b1);
    pad_in = 1'b0; step(); #1;
    chk("R6 no capture without rise", core_in_reg, 1'b1);
    chk("R5 direct tap while driving", core_in_direct, 1'b0);
    in_clk = 1'b1; step(); #1;
    chk("R6 capture on rise", core_in_reg, 1'b0);
    pad_in = 1'b1; step(); #1;
    chk("R6 hold while in_clk high", core_in_reg, 1'b0);
    chk("R5 direct tap follows pad", core_in_direct, 1'b1);
    in_clk = 1'b0; step(); #1;
    chk("R6 hold on fall", core_in_reg, 1'b0);
  endtask

  task automatic t_latch();
    cfg = mk(0,0,0,0,1,0,0,0); in_clk = 1'b0; pad_in = 1'b1;
    pulse_gsr();
    step(); #1;
    chk("R7 closed latch holds", core_in_reg, 1'b0);
    in_clk = 1'b1; step(); #1;
    chk("R7 open latch passes 1", core_in_reg, 1'b1);
    pad_in = 1'b0; step(); #1;
    chk("R7 open latch passes 0", core_in_reg, 1'b0);
    in_clk = 1'b0; pad_in = 1'b1; step(); #1;
    chk("R7 latch holds when low", core_in_reg, 1'b0);
    step(); #1;
    chk("R7 latch still holds", core_in_reg, 1'b0);
    in_clk = 1'b0;
  endtask

  task automatic t_delay();
    for (int den = 0; den < 2; den++) begin
      cfg = mk(0,0,0,0,0,den[0],0,0); in_clk = 1'b0; pad_in = 1'b1;
      repeat (DLY + 2) step();
      pad_in = 1'b0; in_clk = 1'b1; step(); #1;
      chk("R8 ff capture with/without delay", core_in_reg, den[0]);
      in_clk = 1'b0; step();
    end
    cfg = mk(0,0,0,0,1,1,0,0); in_clk = 1'b0; pad_in = 1'b1;
    repeat (DLY + 2) step();
    pad_in = 1'b0; in_clk = 1'b1;
    for (int k = 1; k <= DLY + 1; k++) begin
      step(); #1;
      chk("R8 latch sees delayed pad", core_in_reg, (k <= DLY) ? 1'b1 : 1'b0);
    end
    in_clk = 1'b0; step();
  endtask

  task automatic t_gsr_priority();
    cfg = mk(0,0,0,0,1,0,0,0); in_clk = 1'b1; pad_in = 1'b1;
    pulse_gsr();
    chk("R9 gsr beats open latch", core_in_reg, 1'b0);
    in_clk = 1'b0; step();
    cfg = mk(0,0,0,0,0,0,0,1); pad_in = 1'b0; in_clk = 1'b1;
    pulse_gsr();
    chk("R9 gsr beats in_clk rise", core_in_reg, 1'b1);
    in_clk = 1'b0;
    cfg = mk(1,1,0,0,0,0,1,0); core_out = 1'b0; core_oe = 1'b1; out_clk = 1'b1;
    pulse_gsr();
    chk("R9 gsr beats out_clk rise", pad_out, 1'b1);
    chk("R9 gsr clears enable register", pad_oe, 1'b0);
    out_clk = 1'b0; step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_out_modes();
    t_ff();
    t_latch();
    t_delay();
    t_gsr_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule